// File: doc/BRIEF.md
# Load Criticality Classification Table

This block follows in-flight instructions through a small circular reorder window and decides, for every load, whether it was critical to performance. A front end reports each dispatched instruction with its kind (load, branch or other), its PC and up to two source-producer tags. The block hands back the window slot it used as the instruction's tag. Later events name that tag: issue, branch resolution with a mispredict flag, and L1 hit or miss reports for executed loads. Retire always removes the oldest entry.

A load becomes critical in three ways. Its value reaches, directly or through a chain of consumers, a branch that resolves as mispredicted. Its value reaches another load that misses in L1. Or fewer than `THRESH` independent instructions issue in the `WIN_N` cycles after the load issues. Each entry keeps a transitive ancestor vector over the window slots, so a mispredict or a miss marks every producer load in a single cycle. When a load retires, its criticality bit and PC are presented for one cycle, for use by a cache placement policy or a prefetcher. A mispredict also squashes every entry younger than the branch. Squashed entries never report.

Each slot runs a four-state machine:
- `E_IDLE` to `E_PEND` on alloc.
- `E_PEND` to `E_WATCH` on issue of a load, or `E_PEND` to `E_SETTLED` on issue of any other instruction.
- `E_WATCH` to `E_SETTLED` when the window timer expires.
- Any occupied state to `E_IDLE` on kill, which is retire or squash.

Top module: `load_crit_table`

## Requirements
- R1: After reset `disp_ready_o` is 1, `crit_valid_o` is 0 and `disp_tag_o` is 0.
- R2: Dispatches take consecutive slot tags modulo DEPTH (8), shown on `disp_tag_o` before the dispatch. With DEPTH entries held, `disp_ready_o` is 0 and a dispatch request is ignored.
- R3: A retire removes the oldest entry. One cycle after a load's retire, `crit_valid_o` is 1 for exactly one cycle, carrying `crit_o` and that load's `crit_pc_o`. Retiring a non-load, or retiring with the window empty, gives no strobe.
- R4: A load whose result reaches a mispredicted branch, directly or through any chain of in-window consumers, retires with `crit_o` = 1.
- R5: A load whose result reaches, directly or through a chain, a load reported as an L1 miss retires with `crit_o` = 1. A hit report marks nothing, and the missing load is not marked by its own miss.
- R6: Once a load issues, its window covers the issue events of the next WIN_N (8) cycles. If fewer than THRESH (2) of those events are independent instructions (ones not descended from the load), the load is critical. Issues of descendants, and issues after the window closes, do not count.
- R7: A mispredicted branch squashes every younger entry. Squashed entries never strobe. The next dispatch tag is the branch tag plus one. `disp_ready_o` is 0 in the resolving cycle.
- R8: A source tag naming a slot that is not occupied creates no dependence, so a later load placed in that slot is not marked through it.
- R9: A correctly predicted branch marks nothing and squashes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | Window can accept a dispatch |
| disp_tag_o | output | TW | Tag the next dispatch takes |
| disp_load_i | input | 1 | Dispatched instruction is a load |
| disp_branch_i | input | 1 | Dispatched instruction is a branch |
| disp_pc_i | input | PC_W | PC of the dispatched instruction |
| disp_src0_vld_i | input | 1 | Source 0 names a producer |
| disp_src0_i | input | TW | Source 0 producer tag |
| disp_src1_vld_i | input | 1 | Source 1 names a producer |
| disp_src1_i | input | TW | Source 1 producer tag |
| iss_valid_i | input | 1 | Issue event |
| iss_tag_i | input | TW | Tag of the issued instruction |
| br_valid_i | input | 1 | Branch resolution event |
| br_tag_i | input | TW | Tag of the resolved branch |
| br_mispred_i | input | 1 | Branch was mispredicted |
| l1_valid_i | input | 1 | L1 result report for a load |
| l1_tag_i | input | TW | Tag of the reported load |
| l1_miss_i | input | 1 | Load missed in L1 |
| ret_en_i | input | 1 | Retire the oldest entry |
| crit_valid_o | output | 1 | One-cycle strobe for a retired load |
| crit_o | output | 1 | Retired load was critical |
| crit_pc_o | output | PC_W | PC of the retired load |

## Verification
The bench sweeps chain lengths from a load to a branch or to a consuming load, under both mispredict and correct prediction and under both hit and miss. A design without transitive ancestor vectors would miss every chain longer than one. It places independent issues at window offsets 1, 2, 8 and 9, and issues descendants inside the window. An off-by-one timer would misjudge offset 8 or 9, and an ancestor check that ignores dependence would count descendants as independent. A squash with younger loads behind the branch shows whether the tail rewinds, since a missed rewind retires a squashed load's PC. A source tag that names an already retired slot, later reused by a younger load, exposes a design that trusts the tag without checking occupancy.

// File: rtl/lct_pkg.sv
package lct_pkg;
    typedef enum logic [1:0] {
        E_IDLE    = 2'd0,
        E_PEND    = 2'd1,
        E_WATCH   = 2'd2,
        E_SETTLED = 2'd3
    } ent_state_e;
endpackage

// File: rtl/lct_ring.sv
module lct_ring #(
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int CNTW = TW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            flush,
    input  logic [CNTW-1:0] flush_len,
    output logic [TW-1:0]   head_q,
    output logic [TW-1:0]   tail_q,
    output logic            full,
    output logic            empty
);
    logic [CNTW-1:0] count_q;

    assign full  = (count_q == CNTW'(DEPTH));
    assign empty = (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush) begin
            // survivors are the entries up to and including the branch
            tail_q  <= head_q + flush_len[TW-1:0];
            head_q  <= head_q + TW'(pop);
            count_q <= flush_len - CNTW'(pop);
        end else begin
            tail_q  <= tail_q + TW'(push);
            head_q  <= head_q + TW'(pop);
            count_q <= count_q + CNTW'(push) - CNTW'(pop);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNTW'(DEPTH));
    a_r2_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/lct_entry.sv
module lct_entry
    import lct_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 16,
    parameter int WIN_N  = 8,
    parameter int THRESH = 2,
    localparam int CW    = $clog2(WIN_N + 1),
    localparam int IW    = $clog2(THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             alloc_load,
    input  logic             alloc_br,
    input  logic [PC_W-1:0]  alloc_pc,
    input  logic [DEPTH-1:0] alloc_dep,
    input  logic             kill,
    input  logic [DEPTH-1:0] col_clr,
    input  logic             issue_me,
    input  logic             indep_issue,
    input  logic             mark,
    output ent_state_e       state_q,
    output logic             is_load_q,
    output logic             is_br_q,
    output logic [PC_W-1:0]  pc_q,
    output logic [DEPTH-1:0] dep_q,
    output logic             crit_q
);
    localparam logic [IW-1:0] THR = IW'(THRESH);

    ent_state_e    state_nx;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] ind_q;
    logic [IW-1:0] ind_nx;
    logic          win_end;

    assign win_end = (state_q == E_WATCH) && (cnt_q == CW'(1));
    assign ind_nx  = (indep_issue && ind_q < THR) ? ind_q + IW'(1) : ind_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            E_IDLE:    if (alloc) state_nx = E_PEND;
            E_PEND: begin
                if (kill)          state_nx = E_IDLE;
                else if (issue_me) state_nx = is_load_q ? E_WATCH : E_SETTLED;
            end
            E_WATCH: begin
                if (kill)         state_nx = E_IDLE;
                else if (win_end) state_nx = E_SETTLED;
            end
            E_SETTLED: if (kill) state_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_load_q <= 1'b0;
            is_br_q   <= 1'b0;
            pc_q      <= '0;
            dep_q     <= '0;
            crit_q    <= 1'b0;
            cnt_q     <= '0;
            ind_q     <= '0;
        end else begin
            if (state_q == E_IDLE && alloc) begin
                is_load_q <= alloc_load;
                is_br_q   <= alloc_br;
                pc_q      <= alloc_pc;
                dep_q     <= alloc_dep;
                crit_q    <= 1'b0;
            end else begin
                dep_q <= dep_q & ~col_clr;
                if (mark && is_load_q && state_q != E_IDLE) crit_q <= 1'b1;
                if (win_end && ind_nx < THR)                 crit_q <= 1'b1;
            end
            if (state_q == E_PEND && issue_me && is_load_q) begin
                cnt_q <= CW'(WIN_N);
                ind_q <= '0;
            end else if (state_q == E_WATCH) begin
                cnt_q <= cnt_q - CW'(1);
                ind_q <= ind_nx;
            end
        end
    end

    a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> state_q == E_IDLE);
    a_r6_window_timer: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == E_WATCH |-> (cnt_q != '0 && cnt_q <= CW'(WIN_N)));
endmodule

// File: rtl/load_crit_table.sv
module load_crit_table
    import lct_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 16,
    parameter int WIN_N  = 8,
    parameter int THRESH = 2,
    localparam int TW    = $clog2(DEPTH),
    localparam int CNTW  = TW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid_i,
    output logic            disp_ready_o,
    output logic [TW-1:0]   disp_tag_o,
    input  logic            disp_load_i,
    input  logic            disp_branch_i,
    input  logic [PC_W-1:0] disp_pc_i,
    input  logic            disp_src0_vld_i,
    input  logic [TW-1:0]   disp_src0_i,
    input  logic            disp_src1_vld_i,
    input  logic [TW-1:0]   disp_src1_i,
    input  logic            iss_valid_i,
    input  logic [TW-1:0]   iss_tag_i,
    input  logic            br_valid_i,
    input  logic [TW-1:0]   br_tag_i,
    input  logic            br_mispred_i,
    input  logic            l1_valid_i,
    input  logic [TW-1:0]   l1_tag_i,
    input  logic            l1_miss_i,
    input  logic            ret_en_i,
    output logic            crit_valid_o,
    output logic            crit_o,
    output logic [PC_W-1:0] crit_pc_o
);
    ent_state_e       st    [DEPTH];
    logic [DEPTH-1:0] deps  [DEPTH];
    logic [PC_W-1:0]  pcs   [DEPTH];
    logic [DEPTH-1:0] valid_v, ld_v, br_v, crit_v, mark_v, kill_v;
    logic [DEPTH-1:0] src_dep, col_clr;
    logic [TW-1:0]    head_q, tail_q, age_br;
    logic             full, empty, flush, push, pop, miss_ev, iss_ok;
    logic [CNTW-1:0]  flush_len;

    assign flush     = br_valid_i && br_mispred_i && valid_v[br_tag_i] && br_v[br_tag_i];
    assign miss_ev   = l1_valid_i && l1_miss_i && valid_v[l1_tag_i] && ld_v[l1_tag_i];
    assign iss_ok    = iss_valid_i && valid_v[iss_tag_i];
    assign disp_ready_o = !full && !flush;
    assign push      = disp_valid_i && disp_ready_o;
    assign pop       = ret_en_i && !empty;
    assign age_br    = br_tag_i - head_q;
    assign flush_len = CNTW'(age_br) + CNTW'(1);
    assign disp_tag_o = tail_q;
    assign col_clr   = kill_v;

    lct_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .flush_len (flush_len),
        .head_q    (head_q),
        .tail_q    (tail_q),
        .full      (full),
        .empty     (empty)
    );

    // ancestors of the new entry: each live producer plus its own ancestors
    always_comb begin
        src_dep = '0;
        if (disp_src0_vld_i && valid_v[disp_src0_i]) begin
            src_dep[disp_src0_i] = 1'b1;
            src_dep = src_dep | deps[disp_src0_i];
        end
        if (disp_src1_vld_i && valid_v[disp_src1_i]) begin
            src_dep[disp_src1_i] = 1'b1;
            src_dep = src_dep | deps[disp_src1_i];
        end
        if (pop) src_dep[head_q] = 1'b0;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [TW-1:0] age_i;
        logic          alloc_i, issue_i, indep_i;

        assign age_i     = TW'(i) - head_q;
        assign alloc_i   = push && (tail_q == TW'(i));
        assign issue_i   = iss_ok && (iss_tag_i == TW'(i));
        assign indep_i   = iss_ok && (iss_tag_i != TW'(i)) && !deps[iss_tag_i][i];
        assign kill_v[i] = (pop && head_q == TW'(i)) || (flush && age_i > age_br);
        assign mark_v[i] = (flush && deps[br_tag_i][i]) || (miss_ev && deps[l1_tag_i][i]);
        assign valid_v[i] = (st[i] != E_IDLE);

        lct_entry #(
            .DEPTH(DEPTH), .PC_W(PC_W), .WIN_N(WIN_N), .THRESH(THRESH)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (alloc_i),
            .alloc_load  (disp_load_i),
            .alloc_br    (disp_branch_i),
            .alloc_pc    (disp_pc_i),
            .alloc_dep   (src_dep),
            .kill        (kill_v[i]),
            .col_clr     (col_clr),
            .issue_me    (issue_i),
            .indep_issue (indep_i),
            .mark        (mark_v[i]),
            .state_q     (st[i]),
            .is_load_q   (ld_v[i]),
            .is_br_q     (br_v[i]),
            .pc_q        (pcs[i]),
            .dep_q       (deps[i]),
            .crit_q      (crit_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_valid_o <= 1'b0;
            crit_o       <= 1'b0;
            crit_pc_o    <= '0;
        end else begin
            crit_valid_o <= pop && ld_v[head_q];
            crit_o       <= crit_v[head_q] | mark_v[head_q];
            crit_pc_o    <= pcs[head_q];
        end
    end

    a_r3_strobe_from_retire: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid_o |-> $past(ret_en_i));
    a_r7_tail_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tail_q == TW'($past(br_tag_i) + TW'(1)));
endmodule

// File: tb/load_crit_table_tb.sv
module load_crit_table_tb;
    localparam int DEPTH = 8;
    localparam int PC_W  = 16;
    localparam int TW    = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic disp_valid_i, disp_ready_o, disp_load_i, disp_branch_i;
    logic [TW-1:0] disp_tag_o, disp_src0_i, disp_src1_i;
    logic [PC_W-1:0] disp_pc_i;
    logic disp_src0_vld_i, disp_src1_vld_i;
    logic iss_valid_i; logic [TW-1:0] iss_tag_i;
    logic br_valid_i, br_mispred_i; logic [TW-1:0] br_tag_i;
    logic l1_valid_i, l1_miss_i; logic [TW-1:0] l1_tag_i;
    logic ret_en_i, crit_valid_o, crit_o;
    logic [PC_W-1:0] crit_pc_o;

    load_crit_table u_dut (.*);

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic disp(input bit ld, input bit br, input int pc,
                        input bit v0, input int s0, output int tag);
        tag = int'(disp_tag_o);
        disp_valid_i = 1; disp_load_i = ld; disp_branch_i = br;
        disp_pc_i = PC_W'(pc); disp_src0_vld_i = v0; disp_src0_i = TW'(s0);
        step();
        disp_valid_i = 0; disp_load_i = 0; disp_branch_i = 0; disp_src0_vld_i = 0;
    endtask

    task automatic retire(input bit exp_v, input bit exp_c, input int exp_pc, input string req);
        ret_en_i = 1;
        step();
        ret_en_i = 0;
        chk(crit_valid_o == exp_v, {req, " strobe"}, int'(crit_valid_o), int'(exp_v));
        if (exp_v) begin
            chk(crit_o == exp_c, {req, " crit"}, int'(crit_o), int'(exp_c));
            chk(int'(crit_pc_o) == exp_pc, {req, " pc"}, int'(crit_pc_o), exp_pc);
        end
    endtask

    task automatic issue(input int tag);
        iss_valid_i = 1; iss_tag_i = TW'(tag);
        step();
        iss_valid_i = 0;
    endtask

    task automatic resolve(input int tag, input bit mis);
        br_valid_i = 1; br_tag_i = TW'(tag); br_mispred_i = mis;
        step();
        br_valid_i = 0; br_mispred_i = 0;
    endtask

    task automatic l1rep(input int tag, input bit miss);
        l1_valid_i = 1; l1_tag_i = TW'(tag); l1_miss_i = miss;
        step();
        l1_valid_i = 0; l1_miss_i = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        int t, tu, tl, tb, tf, prev, tl1, tp, tm, tq, ta, tz;
        int ti0, ti1, td0;
        int cp0 [7] = '{0, 1, 1, 0, 1, 1, 2};
        int cp1 [7] = '{0, 0, 2, 0, 8, 9, 3};
        bit cdp [7] = '{0, 0, 0, 1, 0, 0, 1};
        bit cex [7] = '{1, 1, 0, 1, 0, 1, 0};
        disp_valid_i = 0; disp_load_i = 0; disp_branch_i = 0; disp_pc_i = '0;
        disp_src0_vld_i = 0; disp_src0_i = '0; disp_src1_vld_i = 0; disp_src1_i = '0;
        iss_valid_i = 0; iss_tag_i = '0; br_valid_i = 0; br_tag_i = '0; br_mispred_i = 0;
        l1_valid_i = 0; l1_tag_i = '0; l1_miss_i = 0; ret_en_i = 0;
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();

        // R1 reset state
        chk(disp_ready_o == 1, "R1 ready", int'(disp_ready_o), 1);
        chk(crit_valid_o == 0, "R1 strobe", int'(crit_valid_o), 0);
        chk(disp_tag_o == 0, "R1 tag", int'(disp_tag_o), 0);

        // R2 fill the window with non-loads
        for (int i = 0; i < DEPTH; i++) begin
            chk(int'(disp_tag_o) == i, "R2 tag order", int'(disp_tag_o), i);
            disp(0, 0, 16'h10 + i, 0, 0, t);
        end
        chk(disp_ready_o == 0, "R2 full ready", int'(disp_ready_o), 0);
        disp(1, 0, 16'h77, 0, 0, t);   // ignored
        retire(0, 0, 0, "R3 nonload");
        chk(disp_tag_o == 0, "R2 ignored dispatch", int'(disp_tag_o), 0);
        for (int i = 1; i < DEPTH; i++) retire(0, 0, 0, "R3 nonload");
        retire(0, 0, 0, "R3 empty");

        // R4 / R9 chains to a branch
        for (int d = 0; d < 6; d++) begin
            for (int m = 0; m < 2; m++) begin
                disp(1, 0, 16'h200 + d, 0, 0, tu);
                disp(1, 0, 16'h300 + d, 0, 0, tl);
                prev = tl;
                for (int f = 0; f < d; f++) begin
                    disp(0, 0, 16'h400 + f, 1, prev, tf);
                    prev = tf;
                end
                disp(0, 1, 16'h500, 1, prev, tb);
                resolve(tb, m[0]);
                retire(1, 0, 16'h200 + d, "R4 unrelated");
                retire(1, m[0], 16'h300 + d, m ? "R4 chain" : "R9 correct");
                step();
                chk(crit_valid_o == 0, "R3 one-cycle", int'(crit_valid_o), 0);
                for (int f = 0; f < d + 1; f++) retire(0, 0, 0, "R3 nonload");
            end
        end

        // R5 chains to a load that hits or misses
        for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 2; m++) begin
                disp(1, 0, 16'h600 + d, 0, 0, tu);
                disp(1, 0, 16'h700 + d, 0, 0, tl);
                prev = tl;
                for (int f = 0; f < d; f++) begin
                    disp(0, 0, 16'h800 + f, 1, prev, tf);
                    prev = tf;
                end
                disp(1, 0, 16'h900 + d, 1, prev, tl1);
                l1rep(tl1, m[0]);
                retire(1, 0, 16'h600 + d, "R5 unrelated");
                retire(1, m[0], 16'h700 + d, "R5 producer");
                for (int f = 0; f < d; f++) retire(0, 0, 0, "R3 nonload");
                retire(1, 0, 16'h900 + d, "R5 own miss");
            end
        end

        // R6 issue window
        for (int c = 0; c < 7; c++) begin
            disp(1, 0, 16'hA00 + c, 0, 0, tl);
            disp(0, 0, 16'hB00, 0, 0, ti0);
            disp(0, 0, 16'hB01, 0, 0, ti1);
            disp(0, 0, 16'hB02, 1, tl, td0);
            disp(0, 0, 16'hB03, 1, td0, t);
            disp(0, 0, 16'hB04, 1, tl, t);
            issue(tl);
            for (int k = 1; k <= 10; k++) begin
                if (k == cp0[c])                     issue(ti0);
                else if (k == cp1[c])                issue(ti1);
                else if (cdp[c] && k >= 4 && k <= 6) issue(td0 + (k - 4));
                else                                 step();
            end
            retire(1, cex[c], 16'hA00 + c, "R6 window");
            for (int f = 0; f < 5; f++) retire(0, 0, 0, "R3 nonload");
        end

        // R7 squash of younger entries
        disp(1, 0, 16'hC00, 0, 0, ta);
        disp(0, 1, 16'hC01, 1, ta, tb);
        disp(1, 0, 16'hC02, 0, 0, t);
        disp(1, 0, 16'hC03, 0, 0, t);
        br_valid_i = 1; br_tag_i = TW'(tb); br_mispred_i = 1;
        #1;
        chk(disp_ready_o == 0, "R7 ready in flush", int'(disp_ready_o), 0);
        step();
        br_valid_i = 0; br_mispred_i = 0;
        chk(int'(disp_tag_o) == ((tb + 1) % DEPTH), "R7 rewind", int'(disp_tag_o), (tb + 1) % DEPTH);
        disp(1, 0, 16'hC04, 0, 0, tz);
        retire(1, 1, 16'hC00, "R7 producer");
        retire(0, 0, 0, "R7 branch");
        retire(1, 0, 16'hC04, "R7 survivor");
        retire(0, 0, 0, "R7 empty");

        // R8 source naming a freed slot
        disp(1, 0, 16'hD00, 0, 0, tp);
        retire(1, 0, 16'hD00, "R8 producer");
        disp(1, 0, 16'hD01, 1, tp, tm);
        for (int f = 0; f < 6; f++) disp(0, 0, 16'hD10 + f, 0, 0, t);
        disp(1, 0, 16'hD02, 0, 0, tq);
        chk(tq == tp, "R8 slot reuse", tq, tp);
        chk(disp_ready_o == 0, "R2 full again", int'(disp_ready_o), 0);
        l1rep(tm, 1);
        retire(1, 0, 16'hD01, "R8 consumer");
        for (int f = 0; f < 6; f++) retire(0, 0, 0, "R3 nonload");
        retire(1, 0, 16'hD02, "R8 reused slot");

        summary();
    end
endmodule